// File: doc/BRIEF.md
# I2C Target Receive Front End

This block is the bit-level receive side of a write-only I2C target. It runs the SCL and SDA inputs through a chain of flops that brings them into the system clock domain. On the synchronized lines it finds START and STOP conditions and tracks whether a transfer is in progress. It shifts in one bit on each rising SCL edge, most significant bit first.

Acknowledge is not driven on SDA. The block has a dedicated open-drain style output, `ack_n_o`, which is low while the target acknowledges. A board may tie this output to the SDA line to get a normal bus. It may also leave it unconnected; the controller must then be set to ignore the acknowledge slot.

The first byte after any START is compared with a fixed 7-bit target address. Each byte that follows in an addressed write is acknowledged and presented on `byte_o` with a one-cycle strobe. Command decoding is left to logic downstream.

Top module: `i2c_tgt_rx_front`

## Requirements
- R1: While `rst` is high and after it is released, `ack_n_o` is 1, and `busy_o`, `start_o`, `stop_o` and `byte_vld_o` are 0.
- R2: SDA falling while SCL is high gives exactly one cycle of `start_o` and sets `busy_o`.
- R3: SDA rising while SCL is high gives exactly one cycle of `stop_o` and clears `busy_o`.
- R4: SCL pulses that arrive without a preceding START produce no acknowledge and no byte strobe.
- R5: The first byte after a START is acknowledged when its bits 7..1 equal `TARGET_ADDR` and bit 0 (direction, 0 = write) is 0. `ack_n_o` goes low after the 8th SCL falling edge and returns to 1 after the 9th.
- R6: An address byte that differs, or that has bit 0 set to 1, is not acknowledged. No byte after it is acknowledged or strobed until the next START.
- R7: In an addressed write, each data byte appears on `byte_o` with its first-received bit in bit 7. It is acknowledged over the 9th clock, in the same way as the address.
- R8: `byte_vld_o` is high for exactly one cycle per acknowledged data byte. It is high only while `ack_n_o` is 0.
- R9: A STOP or a repeated START in the middle of a byte discards the partial bits. After a repeated START the next byte is treated as an address byte.
- R10: `ack_n_o` changes only in the cycle after a synchronized SCL falling edge, START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| ack_n_o | output | 1 | Acknowledge output, 0 pulls low, 1 released |
| busy_o | output | 1 | Transfer in progress between START and STOP |
| start_o | output | 1 | One-cycle pulse on a START condition |
| stop_o | output | 1 | One-cycle pulse on a STOP condition |
| byte_vld_o | output | 1 | One-cycle strobe for an acknowledged data byte |
| byte_o | output | 8 | Last acknowledged data byte |

## Verification
The bench builds the block with `TARGET_ADDR` = 7'h2C instead of the default, and with three synchronizer stages instead of two. The non-default address shows that the comparison uses the parameter. With it, the bench can present addresses one bit away, in the address field and in the direction bit. The longer synchronizer shifts every output by an extra cycle. Because of this the bench holds each bus phase for several clocks rather than relying on a fixed latency.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_SKIP
  } rx_state_t;

  typedef struct packed {
    logic start;
    logic stop;
    logic scl_rise;
    logic scl_fall;
    logic sda;
  } bus_evt_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  // idle bus lines are high, so the chain resets to ones
  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];

  initial begin
    AST_SYNC_DEPTH: assert (STAGES >= 2); // R10
  end

endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events
  import i2c_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     scl_s,
  input  logic     sda_s,
  output bus_evt_t evt,
  output logic     start_o,
  output logic     stop_o,
  output logic     busy_o
);

  logic scl_q, sda_q;

  assign evt.start    = scl_s & scl_q & sda_q & ~sda_s;
  assign evt.stop     = scl_s & scl_q & ~sda_q & sda_s;
  assign evt.scl_rise = scl_s & ~scl_q;
  assign evt.scl_fall = ~scl_s & scl_q;
  assign evt.sda      = sda_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      start_o <= 1'b0;
      stop_o  <= 1'b0;
      busy_o  <= 1'b0;
    end else begin
      scl_q   <= scl_s;
      sda_q   <= sda_s;
      start_o <= evt.start;
      stop_o  <= evt.stop;
      if (evt.start)     busy_o <= 1'b1;
      else if (evt.stop) busy_o <= 1'b0;
    end
  end

  AST_START_STOP_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(start_o && stop_o)); // R2
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o); // R2
  AST_STOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    stop_o |=> !stop_o); // R3
  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> start_o); // R2
  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> stop_o); // R3

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_rx_pkg::*;
#(
  parameter int               DATA_W      = 8,
  parameter int               ADDR_W      = 7,
  parameter logic [ADDR_W-1:0] TARGET_ADDR = 7'h3A
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_evt_t          evt,
  output logic              ack_n_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              byte_vld_o
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  rx_state_t         state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] shreg;
  logic              addr_hit;

  // direction bit sits at bit 0, address above it
  assign addr_hit = (shreg[DATA_W-1 -: ADDR_W] == TARGET_ADDR) && (shreg[0] == 1'b0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      bit_cnt    <= '0;
      shreg      <= '0;
      ack_n_o    <= 1'b1;
      byte_o     <= '0;
      byte_vld_o <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      if (evt.stop) begin
        state   <= ST_IDLE;
        bit_cnt <= '0;
        ack_n_o <= 1'b1;
      end else if (evt.start) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        ack_n_o <= 1'b1;
      end else begin
        case (state)
          ST_ADDR, ST_DATA: begin
            if (evt.scl_rise && bit_cnt != FULL) begin
              shreg   <= {shreg[DATA_W-2:0], evt.sda};
              bit_cnt <= bit_cnt + CNT_W'(1);
            end else if (evt.scl_fall && bit_cnt == FULL) begin
              bit_cnt <= '0;
              if (state == ST_ADDR) begin
                if (addr_hit) begin
                  state   <= ST_ADDR_ACK;
                  ack_n_o <= 1'b0;
                end else begin
                  state <= ST_SKIP;
                end
              end else begin
                state      <= ST_DATA_ACK;
                ack_n_o    <= 1'b0;
                byte_o     <= shreg;
                byte_vld_o <= 1'b1;
              end
            end
          end
          ST_ADDR_ACK, ST_DATA_ACK: begin
            if (evt.scl_fall) begin
              ack_n_o <= 1'b1;
              state   <= ST_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_ACK_ON_EVENT: assert property (@(posedge clk) disable iff (rst)
    !$stable(ack_n_o) |-> $past(evt.scl_fall | evt.start | evt.stop)); // R10
  AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    byte_vld_o |=> !byte_vld_o); // R8
  AST_VLD_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
    byte_vld_o |-> !ack_n_o); // R8
  AST_QUIET_WHEN_UNADDRESSED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SKIP || state == ST_IDLE) |-> (ack_n_o && !byte_vld_o)); // R6

endmodule

// File: rtl/i2c_tgt_rx_front.sv
module i2c_tgt_rx_front #(
  parameter int               SYNC_STAGES = 2,
  parameter logic [6:0]       TARGET_ADDR = 7'h3A
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       ack_n_o,
  output logic       busy_o,
  output logic       start_o,
  output logic       stop_o,
  output logic       byte_vld_o,
  output logic [7:0] byte_o
);

  import i2c_rx_pkg::*;

  logic [1:0] lines_s;
  bus_evt_t   evt;

  i2c_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_i, sda_i}),
    .q   (lines_s)
  );

  i2c_bus_events i_events (
    .clk     (clk),
    .rst     (rst),
    .scl_s   (lines_s[1]),
    .sda_s   (lines_s[0]),
    .evt     (evt),
    .start_o (start_o),
    .stop_o  (stop_o),
    .busy_o  (busy_o)
  );

  i2c_byte_engine #(.DATA_W(8), .ADDR_W(7), .TARGET_ADDR(TARGET_ADDR)) i_engine (
    .clk        (clk),
    .rst        (rst),
    .evt        (evt),
    .ack_n_o    (ack_n_o),
    .byte_o     (byte_o),
    .byte_vld_o (byte_vld_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (ack_n_o && !busy_o && !byte_vld_o)); // R1

endmodule

// File: tb/test_i2c_tgt_rx_front.sv
module test_i2c_tgt_rx_front;

  localparam int H = 8;

  typedef struct packed {
    logic [7:0] first;
    logic [7:0] data;
    logic       hit;
  } vec_t;

  // target address 7'h2C: write byte 0x58, read byte 0x59
  localparam vec_t VEC [4] = '{
    '{first: 8'h58, data: 8'hA5, hit: 1'b1},
    '{first: 8'h59, data: 8'h3C, hit: 1'b0},
    '{first: 8'h5A, data: 8'hFF, hit: 1'b0},
    '{first: 8'h58, data: 8'h01, hit: 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda = 1'b1;
  logic ack_n, busy, start_p, stop_p, vld;
  logic [7:0] dbyte;

  int total = 0, fails = 0;
  int vld_cnt = 0, start_cnt = 0, stop_cnt = 0;
  logic [7:0] last_byte = 8'h00;
  bit done = 1'b0;

  always #5 clk = ~clk;

  i2c_tgt_rx_front #(.SYNC_STAGES(3), .TARGET_ADDR(7'h2C)) i_i2c_tgt_rx_front (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda),
    .ack_n_o(ack_n), .busy_o(busy), .start_o(start_p), .stop_o(stop_p),
    .byte_vld_o(vld), .byte_o(dbyte)
  );

  always @(negedge clk) begin
    if (vld) begin vld_cnt++; last_byte = dbyte; end
    if (start_p) start_cnt++;
    if (stop_p) stop_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold();
    repeat (H) @(negedge clk);
  endtask

  task automatic do_start();
    scl = 1'b0; hold(); sda = 1'b1; hold(); scl = 1'b1; hold(); sda = 1'b0; hold();
  endtask

  task automatic do_stop();
    scl = 1'b0; hold(); sda = 1'b0; hold(); scl = 1'b1; hold(); sda = 1'b1; hold();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      scl = 1'b0; hold(); sda = b[i]; hold(); scl = 1'b1; hold();
    end
  endtask

  // eight bits then the ninth clock; reports whether ack was held low
  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    scl = 1'b0; hold(); sda = 1'b1; hold();
    acked = !ack_n;
    scl = 1'b1; hold();
    acked = acked & !ack_n;
    scl = 1'b0; hold();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    bit ak;
    int v0, s0, p0;
    repeat (4) @(negedge clk);
    chk("R1 ack in reset", ack_n, 1);
    chk("R1 busy in reset", busy, 0);
    rst = 1'b0;
    hold();
    chk("R1 ack after reset", ack_n, 1);
    chk("R1 busy after reset", busy, 0);
    chk("R1 strobes after reset", vld_cnt + start_cnt + stop_cnt, 0);

    // R4: bits without START
    send_byte(8'h58, ak);
    chk("R4 no ack without start", ak, 0);
    send_byte(8'h11, ak);
    chk("R4 no strobe without start", vld_cnt, 0);
    chk("R4 busy stays low", busy, 0);

    // table walk: R5 R6 R7
    foreach (VEC[k]) begin
      v0 = vld_cnt; s0 = start_cnt; p0 = stop_cnt;
      do_start();
      chk("R2 one start pulse", start_cnt - s0, 1);
      chk("R2 busy after start", busy, 1);
      send_byte(VEC[k].first, ak);
      chk("R5 R6 address ack", ak, VEC[k].hit);
      chk("R5 ack released after ninth clock", ack_n, 1);
      send_byte(VEC[k].data, ak);
      chk("R7 data ack", ak, VEC[k].hit);
      chk("R8 one strobe per byte", vld_cnt - v0, VEC[k].hit ? 1 : 0);
      if (VEC[k].hit) chk("R7 byte value", last_byte, VEC[k].data);
      do_stop();
      chk("R3 one stop pulse", stop_cnt - p0, 1);
      chk("R3 busy after stop", busy, 0);
    end

    // R7: several bytes in one write
    v0 = vld_cnt;
    do_start();
    send_byte(8'h58, ak);
    send_byte(8'h80, ak);
    chk("R7 first of burst", last_byte, 8'h80);
    send_byte(8'h7E, ak);
    chk("R7 second of burst acked", ak, 1);
    chk("R7 second of burst", last_byte, 8'h7E);
    chk("R8 burst strobes", vld_cnt - v0, 2);

    // R9: repeated START mid byte, new address phase
    send_bits(8'hF0, 3);
    do_start();
    chk("R9 busy through repeated start", busy, 1);
    send_byte(8'h58, ak);
    chk("R9 address after repeated start acked", ak, 1);
    send_byte(8'hC3, ak);
    chk("R9 partial bits dropped", last_byte, 8'hC3);
    chk("R9 strobe count", vld_cnt - v0, 3);

    // R6: mismatched address, then a byte that equals the address
    do_start();
    send_byte(8'h5A, ak);
    chk("R6 mismatch not acked", ak, 0);
    v0 = vld_cnt;
    send_byte(8'h58, ak);
    chk("R6 later byte not acked", ak, 0);
    chk("R6 no strobe after mismatch", vld_cnt - v0, 0);

    // R9: STOP mid byte, then bits without START
    do_start();
    send_byte(8'h58, ak);
    send_bits(8'hAA, 4);
    do_stop();
    chk("R9 busy cleared", busy, 0);
    v0 = vld_cnt;
    send_byte(8'h55, ak);
    chk("R9 bits after stop ignored", ak, 0);
    chk("R9 no strobe after stop", vld_cnt - v0, 0);
    chk("R10 ack idle at end", ack_n, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule